// File: doc/BRIEF.md
# Privileged Control Register File

This block keeps the supervisor and hypervisor control state of one processor strand. Software-visible registers sit behind a single address-decoded access port: each register has its own write mask, and a small stack of trap records is selected by the current trap level. The trap base, processor state, trap level, interrupt level and hypervisor state registers are held here, along with context and partition identifiers, a load/store control register, eight scratch registers and eight interrupt-queue pointers.

An access has no wait states. Read data and the error flag are combinational in the address. A write takes effect at the next rising clock edge. Any access the block cannot honour raises the error flag and changes no state. Such accesses are unknown addresses, the performance-monitor addresses, and trap-record accesses while the trap level is zero.

The block has two other outputs. It drives a packed context word every cycle for the memory-management unit. It also raises a trap-level-zero interrupt request, which is re-evaluated on each trap-level write.

Top module: `priv_ctl_regfile`

## Requirements
- R1: After reset, hypervisor state (0x0C) reads 0x800 and strand status (0x0D) reads 0x50000. Every other register, trap record, scratch register and queue pointer reads zero. `tlz_irq` is 0 and `mmu_ctx` is 0.
- R2: A write to the trap base register (0x08) stores the value with bits 14:0 cleared.
- R3: A write to processor state (0x09) keeps only the bits in mask 0x0BDE; all other bits read back as zero.
- R4: Trap records are at 0x00 (trap PC), 0x01 (next PC), 0x02 (trap state), 0x03 (trap type) and 0x04 (hypervisor trap state). Each is read and written at stack entry TL−1, and each entry keeps its own value.
- R5: A trap-record access while TL = 0 sets `acc_err` and writes nothing.
- R6: A write to the trap level (0x0A) stores the value, clamped to MAX_TL.
- R7: On a trap-level write, `tlz_irq` is set from the next edge when the new TL is 0, hypervisor state bit 0 is 1 and bit 2 is 0; otherwise it is cleared. It holds between trap-level writes.
- R8: `mmu_ctx` carries the following fields; all other bits are 0:
  - bit 0: hypervisor state bit 2
  - bit 1: hypervisor state bit 5
  - bit 2: processor state bit 2
  - bit 3: processor state bit 3
  - bits 5:4: load/store control (0x13) bits 3:2
  - bits 15:8: partition id (0x12) bits 7:0
  - bits 18:16: TL
  - bits 47:32: primary context (0x10) bits 15:0
  - bits 63:48: secondary context (0x11) bits 15:0
- R9: A read of the FP register state (0x0E) returns the stored value with bits 1:0 forced to 1.
- R10: Accesses to the performance addresses 0x14 and 0x15 set `acc_err`.
- R11: Any address outside the register map sets `acc_err`, and a write there changes no register. The register map is 0x00–0x04, 0x08–0x0E, 0x10–0x13 and 0x20–0x2F.
- R12: Scratch registers (0x20–0x27) and queue pointers (0x28–0x2F) store full 64-bit values, each independently. PIL is at 0x0B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_en | input | 1 | Access valid this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 6 | Register address |
| acc_wdata | input | 64 | Write data |
| acc_rdata | output | 64 | Read data (combinational, 0 on error) |
| acc_err | output | 1 | Access refused (combinational) |
| tlz_irq | output | 1 | Trap-level-zero interrupt request |
| mmu_ctx | output | 64 | Packed context word for the MMU |

## Verification
The assertions check the following on every cycle:
- masking of trap-base and processor-state writes;
- the trap-level bound;
- the set, clear and hold behaviour of the trap-level-zero request;
- the zero padding and trap-level field of the context word;
- the error flag for the performance and trap-level-zero cases;
- that a refused write leaves the main registers untouched.

Only the bench scenarios can show the following:
- values read back from reset;
- that trap records at different levels stay separate;
- the FP read override;
- every field position of the context word;
- that scratch and queue entries do not alias.

// File: rtl/pcr_pkg.sv
// Package: shared address map, masks and decode record for the
// privileged control register file. Assumes a 6-bit register address.
package pcr_pkg;
    localparam int ADDR_W   = 6;
    localparam int DATA_W   = 64;
    localparam int NUM_TREC = 5;   // trap record fields
    localparam int BANK_N   = 8;   // scratch and queue entries
    localparam int BANK_IW  = $clog2(BANK_N);

    localparam logic [ADDR_W-1:0] A_TBA     = 6'h08;
    localparam logic [ADDR_W-1:0] A_PSTATE  = 6'h09;
    localparam logic [ADDR_W-1:0] A_TL      = 6'h0A;
    localparam logic [ADDR_W-1:0] A_PIL     = 6'h0B;
    localparam logic [ADDR_W-1:0] A_HPSTATE = 6'h0C;
    localparam logic [ADDR_W-1:0] A_STRAND  = 6'h0D;
    localparam logic [ADDR_W-1:0] A_FPRS    = 6'h0E;
    localparam logic [ADDR_W-1:0] A_PRICTX  = 6'h10;
    localparam logic [ADDR_W-1:0] A_SECCTX  = 6'h11;
    localparam logic [ADDR_W-1:0] A_PART    = 6'h12;
    localparam logic [ADDR_W-1:0] A_LSU     = 6'h13;
    localparam logic [ADDR_W-1:0] A_PERFC   = 6'h14;
    localparam logic [ADDR_W-1:0] A_PERFN   = 6'h15;

    localparam logic [DATA_W-1:0] PSTATE_KEEP = 64'h0000_0000_0000_0BDE;
    localparam logic [DATA_W-1:0] TBA_KEEP    = ~64'h7FFF;
    localparam logic [DATA_W-1:0] HP_RESET    = 64'h800;
    localparam logic [DATA_W-1:0] STRAND_RST  = 64'h5_0000;
    localparam logic [DATA_W-1:0] FPRS_FORCE  = 64'h3;
    localparam int HP_TLZ   = 0;
    localparam int HP_HPRIV = 2;
    localparam int HP_RED   = 5;
    localparam int PS_PRIV  = 2;
    localparam int PS_AM    = 3;

    typedef struct packed {
        logic                err;
        logic                trec_hit;
        logic [2:0]          trec_field;
        logic                scr_hit;
        logic                que_hit;
        logic [BANK_IW-1:0]  idx;
    } pcr_dec_t;
endpackage

// File: rtl/pcr_decode.sv
// Module: address decoder. Classifies an address as trap record, scalar,
// scratch or queue entry, and flags refused accesses. Assumes 6-bit map.
module pcr_decode
    import pcr_pkg::*;
#(
    parameter int TL_W = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [TL_W-1:0]   tl,
    output pcr_dec_t          dec
);
    logic known;

    // Decode the address group and the entry index.
    always_comb begin
        dec   = '0;
        known = 1'b0;
        dec.idx = addr[BANK_IW-1:0];
        case (addr[5:3])
            3'd0: begin
                if (addr[2:0] < 3'(NUM_TREC)) begin
                    dec.trec_hit   = 1'b1;
                    dec.trec_field = addr[2:0];
                    known          = 1'b1;
                end
            end
            3'd1: known = (addr[2:0] <= 3'd6);
            3'd2: known = (addr[2:0] <= 3'd3);
            3'd4: begin
                dec.scr_hit = 1'b1;
                known       = 1'b1;
            end
            3'd5: begin
                dec.que_hit = 1'b1;
                known       = 1'b1;
            end
            default: known = 1'b0;
        endcase
        dec.err = !known || (dec.trec_hit && (tl == '0));
    end
endmodule

// File: rtl/pcr_bank.sv
// Module: N-entry register bank with one write port and one read port.
// Assumes the read index stays below N.
module pcr_bank #(
    parameter int N = 8,
    parameter int W = 64,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] idx,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] ent_q [N];

    for (genvar g = 0; g < N; g++) begin : g_ent
        // Store one entry when it is addressed by a write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ent_q[g] <= '0;
            else if (we && (idx == IW'(g)))
                ent_q[g] <= wdata;
        end
    end

    // Select the addressed entry.
    always_comb rdata = ent_q[idx];
endmodule

// File: rtl/pcr_trap_stack.sv
// Module: trap record stack, one bank per record field, DEPTH entries.
// Assumes the caller supplies entry TL-1 and a field below NF.
module pcr_trap_stack #(
    parameter int DEPTH = 6,
    parameter int W     = 64,
    parameter int NF    = 5,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [2:0]    field,
    input  logic [IW-1:0] idx,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] fld_rd [NF];

    for (genvar f = 0; f < NF; f++) begin : g_fld
        pcr_bank #(.N(DEPTH), .W(W)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (we && (field == 3'(f))),
            .idx   (idx),
            .wdata (wdata),
            .rdata (fld_rd[f])
        );
    end

    // Pick the field being accessed.
    always_comb begin
        rdata = '0;
        for (int f = 0; f < NF; f++)
            if (field == 3'(f)) rdata = fld_rd[f];
    end
endmodule

// File: rtl/pcr_ctx_pack.sv
// Module: packs privilege, partition, trap level and context ids into the
// MMU context word. Purely combinational.
module pcr_ctx_pack (
    input  logic        hpriv,
    input  logic        red,
    input  logic        priv,
    input  logic        am,
    input  logic [1:0]  lsu_bits,
    input  logic [7:0]  part,
    input  logic [2:0]  tl,
    input  logic [15:0] pri_ctx,
    input  logic [15:0] sec_ctx,
    output logic [63:0] ctx
);
    // Assemble the packed word with zero padding.
    always_comb ctx = {sec_ctx, pri_ctx, 13'b0, tl, part, 2'b0,
                       lsu_bits, am, priv, red, hpriv};
endmodule

// File: rtl/priv_ctl_regfile.sv
// Module: privileged control register file of one strand. Holds scalar
// control registers, the trap record stack, scratch and queue banks;
// masks writes, raises the trap-level-zero request and drives the MMU
// context word. Assumes MAX_TL >= 2 and one access per cycle.
module priv_ctl_regfile
    import pcr_pkg::*;
#(
    parameter int MAX_TL = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] acc_rdata,
    output logic              acc_err,
    output logic              tlz_irq,
    output logic [DATA_W-1:0] mmu_ctx
);
    localparam int TL_W  = $clog2(MAX_TL + 1);
    localparam int TS_IW = $clog2(MAX_TL);

    pcr_dec_t dec;
    logic [DATA_W-1:0] tba_q, pstate_q, pil_q, hpstate_q, strand_q, fprs_q;
    logic [DATA_W-1:0] pri_q, sec_q, part_q, lsu_q;
    logic [TL_W-1:0]   tl_q, tl_new, tl_m1;
    logic              tlz_q, wr_ok;
    logic [DATA_W-1:0] trec_rd, scr_rd, que_rd;
    logic [7:0]        tl8;

    pcr_decode #(.TL_W(TL_W)) u_dec (
        .addr (acc_addr),
        .tl   (tl_q),
        .dec  (dec)
    );

    // Qualify a write that the decoder accepted.
    always_comb wr_ok = acc_en && acc_wr && !dec.err;
    // Clamp the written trap level to the stack depth.
    always_comb tl_new = (acc_wdata > DATA_W'(MAX_TL)) ? TL_W'(MAX_TL)
                                                       : acc_wdata[TL_W-1:0];
    // Current trap record index is TL-1.
    always_comb tl_m1 = tl_q - TL_W'(1);

    pcr_trap_stack #(.DEPTH(MAX_TL), .W(DATA_W), .NF(NUM_TREC)) u_trec (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_ok && dec.trec_hit),
        .field (dec.trec_field),
        .idx   (TS_IW'(tl_m1)),
        .wdata (acc_wdata),
        .rdata (trec_rd)
    );

    pcr_bank #(.N(BANK_N), .W(DATA_W)) u_scr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_ok && dec.scr_hit),
        .idx   (dec.idx),
        .wdata (acc_wdata),
        .rdata (scr_rd)
    );

    pcr_bank #(.N(BANK_N), .W(DATA_W)) u_que (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_ok && dec.que_hit),
        .idx   (dec.idx),
        .wdata (acc_wdata),
        .rdata (que_rd)
    );

    // Scalar register writes with their per-register masks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tba_q     <= '0;
            pstate_q  <= '0;
            tl_q      <= '0;
            pil_q     <= '0;
            hpstate_q <= HP_RESET;
            strand_q  <= STRAND_RST;
            fprs_q    <= '0;
            pri_q     <= '0;
            sec_q     <= '0;
            part_q    <= '0;
            lsu_q     <= '0;
        end else if (wr_ok) begin
            case (acc_addr)
                A_TBA:     tba_q     <= acc_wdata & TBA_KEEP;
                A_PSTATE:  pstate_q  <= acc_wdata & PSTATE_KEEP;
                A_TL:      tl_q      <= tl_new;
                A_PIL:     pil_q     <= acc_wdata;
                A_HPSTATE: hpstate_q <= acc_wdata;
                A_STRAND:  strand_q  <= acc_wdata;
                A_FPRS:    fprs_q    <= acc_wdata;
                A_PRICTX:  pri_q     <= acc_wdata;
                A_SECCTX:  sec_q     <= acc_wdata;
                A_PART:    part_q    <= acc_wdata;
                A_LSU:     lsu_q     <= acc_wdata;
                default:   ;
            endcase
        end
    end

    // Re-evaluate the trap-level-zero request on each trap-level write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tlz_q <= 1'b0;
        else if (wr_ok && (acc_addr == A_TL))
            tlz_q <= (tl_new == '0) && hpstate_q[HP_TLZ] && !hpstate_q[HP_HPRIV];
    end

    // Read data multiplexer; zero on a refused access.
    always_comb begin
        acc_rdata = '0;
        if (!dec.err) begin
            if (dec.trec_hit)     acc_rdata = trec_rd;
            else if (dec.scr_hit) acc_rdata = scr_rd;
            else if (dec.que_hit) acc_rdata = que_rd;
            else begin
                case (acc_addr)
                    A_TBA:     acc_rdata = tba_q;
                    A_PSTATE:  acc_rdata = pstate_q;
                    A_TL:      acc_rdata = DATA_W'(tl_q);
                    A_PIL:     acc_rdata = pil_q;
                    A_HPSTATE: acc_rdata = hpstate_q;
                    A_STRAND:  acc_rdata = strand_q;
                    A_FPRS:    acc_rdata = fprs_q | FPRS_FORCE;
                    A_PRICTX:  acc_rdata = pri_q;
                    A_SECCTX:  acc_rdata = sec_q;
                    A_PART:    acc_rdata = part_q;
                    A_LSU:     acc_rdata = lsu_q;
                    default:   acc_rdata = '0;
                endcase
            end
        end
    end

    // Flag refused accesses only when an access is presented.
    always_comb acc_err = acc_en && dec.err;
    always_comb tlz_irq = tlz_q;
    // Widen the trap level for the 3-bit context field.
    always_comb tl8 = 8'(tl_q);

    pcr_ctx_pack u_ctx (
        .hpriv    (hpstate_q[HP_HPRIV]),
        .red      (hpstate_q[HP_RED]),
        .priv     (pstate_q[PS_PRIV]),
        .am       (pstate_q[PS_AM]),
        .lsu_bits (lsu_q[3:2]),
        .part     (part_q[7:0]),
        .tl       (tl8[2:0]),
        .pri_ctx  (pri_q[15:0]),
        .sec_ctx  (sec_q[15:0]),
        .ctx      (mmu_ctx)
    );
endmodule

// File: rtl/pcr_chk.sv
// Module: assertion checker for the privileged control register file,
// bound to every instance of the top module.
module pcr_chk
    import pcr_pkg::*;
#(
    parameter int MAX_TL = 6,
    localparam int TL_W  = $clog2(MAX_TL + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_en,
    input logic              acc_wr,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [DATA_W-1:0] acc_wdata,
    input logic              acc_err,
    input logic              tlz_irq,
    input logic [DATA_W-1:0] mmu_ctx,
    input logic [DATA_W-1:0] tba_q,
    input logic [DATA_W-1:0] pstate_q,
    input logic [DATA_W-1:0] hpstate_q,
    input logic [TL_W-1:0]   tl_q
);
    logic tl_wr;
    always_comb tl_wr = acc_en && acc_wr && (acc_addr == A_TL);

    // R2
    tba_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_wr && acc_addr == A_TBA) |=> (tba_q == ($past(acc_wdata) & ~64'h7FFF)));
    // R3
    pstate_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_wr && acc_addr == A_PSTATE) |=> (pstate_q == ($past(acc_wdata) & 64'h0BDE)));
    // R5
    trec_tl0_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_addr <= 6'h04 && tl_q == '0) |-> acc_err);
    // R6
    tl_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(tl_q) <= MAX_TL));
    // R7
    tlz_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tl_wr && acc_wdata == '0 && hpstate_q[0] && !hpstate_q[2]) |=> tlz_irq);
    // R7
    tlz_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tl_wr && (acc_wdata != '0 || !hpstate_q[0] || hpstate_q[2])) |=> !tlz_irq);
    // R7
    tlz_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tl_wr |=> $stable(tlz_irq));
    // R8
    ctx_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mmu_ctx[31:19] == '0) && (mmu_ctx[7:6] == '0));
    // R8
    ctx_tl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mmu_ctx[18:16] == 3'(tl_q)));
    // R10
    perf_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && (acc_addr == A_PERFC || acc_addr == A_PERFN)) |-> acc_err);
    // R11
    refused_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_wr && acc_err) |=> ($stable(tl_q) && $stable(pstate_q)
                                           && $stable(tba_q) && $stable(hpstate_q)));
endmodule

bind priv_ctl_regfile pcr_chk #(.MAX_TL(MAX_TL)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_en    (acc_en),
    .acc_wr    (acc_wr),
    .acc_addr  (acc_addr),
    .acc_wdata (acc_wdata),
    .acc_err   (acc_err),
    .tlz_irq   (tlz_irq),
    .mmu_ctx   (mmu_ctx),
    .tba_q     (tba_q),
    .pstate_q  (pstate_q),
    .hpstate_q (hpstate_q),
    .tl_q      (tl_q)
);

// File: tb/sim_priv_ctl_regfile.sv
module sim_priv_ctl_regfile;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en = 1'b0;
    logic        acc_wr = 1'b0;
    logic [5:0]  acc_addr = '0;
    logic [63:0] acc_wdata = '0;
    logic [63:0] acc_rdata;
    logic        acc_err;
    logic        tlz_irq;
    logic [63:0] mmu_ctx;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    priv_ctl_regfile #(.MAX_TL(6)) u0 (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .acc_err(acc_err), .tlz_irq(tlz_irq), .mmu_ctx(mmu_ctx)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [63:0] d, output logic err);
        @(negedge clk);
        acc_en = 1'b1; acc_wr = 1'b1; acc_addr = a; acc_wdata = d;
        #1 err = acc_err;
        @(negedge clk);
        acc_en = 1'b0; acc_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [63:0] d, output logic err);
        @(negedge clk);
        acc_en = 1'b1; acc_wr = 1'b0; acc_addr = a;
        #1 d = acc_rdata; err = acc_err;
        acc_en = 1'b0;
    endtask

    task automatic t_reset;
        logic [63:0] d; logic e;
        rd(6'h0C, d, e); check("R1", "hpstate", d, 64'h800);
        rd(6'h0D, d, e); check("R1", "strand", d, 64'h50000);
        rd(6'h08, d, e); check("R1", "tba", d, 64'h0);
        rd(6'h24, d, e); check("R1", "scratch4", d, 64'h0);
        check("R1", "irq", {63'b0, tlz_irq}, 64'h0);
        check("R1", "ctx", mmu_ctx, 64'h0);
    endtask

    task automatic t_masks;
        logic [63:0] d; logic e;
        wr(6'h08, '1, e); rd(6'h08, d, e);
        check("R2", "tba", d, 64'hFFFF_FFFF_FFFF_8000);
        wr(6'h09, '1, e); rd(6'h09, d, e);
        check("R3", "pstate", d, 64'h0BDE);
        rd(6'h0E, d, e); check("R9", "fprs reset", d, 64'h3);
        wr(6'h0E, 64'h4, e); rd(6'h0E, d, e);
        check("R9", "fprs", d, 64'h7);
    endtask

    task automatic t_trap_stack;
        logic [63:0] d; logic e;
        rd(6'h00, d, e); check("R5", "err tl0 read", {63'b0, e}, 64'h1);
        wr(6'h00, 64'h77, e); check("R5", "err tl0 write", {63'b0, e}, 64'h1);
        wr(6'h0A, 64'd1, e);
        rd(6'h00, d, e); check("R5", "no write at tl0", d, 64'h0);
        wr(6'h00, 64'hA1, e); wr(6'h03, 64'h1F1, e);
        wr(6'h0A, 64'd2, e);
        wr(6'h00, 64'hB2, e);
        rd(6'h00, d, e); check("R4", "tpc tl2", d, 64'hB2);
        rd(6'h03, d, e); check("R4", "tt tl2", d, 64'h0);
        wr(6'h0A, 64'd1, e);
        rd(6'h00, d, e); check("R4", "tpc tl1", d, 64'hA1);
        rd(6'h03, d, e); check("R4", "tt tl1", d, 64'h1F1);
        wr(6'h0A, 64'd7, e);
        rd(6'h0A, d, e); check("R6", "tl clamp", d, 64'd6);
        wr(6'h04, 64'h66, e); rd(6'h04, d, e);
        check("R6", "htstate top", d, 64'h66);
    endtask

    task automatic t_tlz;
        logic e;
        wr(6'h0C, 64'h1, e); wr(6'h0A, 64'd0, e);
        check("R7", "irq set", {63'b0, tlz_irq}, 64'h1);
        wr(6'h0B, 64'h5, e);
        check("R7", "irq hold", {63'b0, tlz_irq}, 64'h1);
        wr(6'h0A, 64'd2, e);
        check("R7", "irq clear", {63'b0, tlz_irq}, 64'h0);
        wr(6'h0C, 64'h5, e); wr(6'h0A, 64'd0, e);
        check("R7", "irq hpriv", {63'b0, tlz_irq}, 64'h0);
    endtask

    task automatic t_errors;
        logic [63:0] d; logic e;
        wr(6'h09, 64'h4, e);
        rd(6'h14, d, e); check("R10", "perf ctl", {63'b0, e}, 64'h1);
        wr(6'h15, '1, e); check("R10", "perf cnt", {63'b0, e}, 64'h1);
        wr(6'h3F, '1, e); check("R11", "unknown err", {63'b0, e}, 64'h1);
        wr(6'h19, '1, e); check("R11", "gap err", {63'b0, e}, 64'h1);
        rd(6'h09, d, e); check("R11", "pstate kept", d, 64'h4);
        rd(6'h0A, d, e); check("R11", "tl kept", d, 64'h0);
    endtask

    task automatic t_ctx;
        logic e;
        wr(6'h0C, 64'h24, e); wr(6'h09, 64'hC, e); wr(6'h13, 64'hC, e);
        wr(6'h12, 64'hAB, e); wr(6'h0A, 64'd3, e);
        wr(6'h10, 64'h1234, e); wr(6'h11, 64'hBEEF, e);
        check("R8", "ctx all", mmu_ctx, 64'hBEEF_1234_0003_AB3F);
        wr(6'h0C, 64'h0, e);
        check("R8", "ctx no hpriv", mmu_ctx, 64'hBEEF_1234_0003_AB3C);
    endtask

    task automatic t_banks;
        logic [63:0] d; logic e;
        for (int i = 0; i < 16; i++)
            wr(6'h20 + 6'(i), 64'hC0DE_0000_0000_0000 + 64'(i * 3), e);
        for (int i = 0; i < 16; i++) begin
            rd(6'h20 + 6'(i), d, e);
            check("R12", "bank entry", d, 64'hC0DE_0000_0000_0000 + 64'(i * 3));
        end
        wr(6'h0B, 64'hF, e); rd(6'h0B, d, e); check("R12", "pil", d, 64'hF);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset;
        t_masks;
        t_trap_stack;
        t_tlz;
        t_errors;
        t_ctx;
        t_banks;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule